// File: doc/BRIEF.md
# Stop-Grant Interrupt Latch and Wake Request

While the package sits in a clock-stopped, stop-grant-class state, the core cannot take interrupts. This block stands in for it during that time. Four interrupt sources are watched: system-management, init and two local interrupt lines. A monitor event is watched as well. Each source owns one pending bit, so any number of pulses on a source leave exactly one pending event for it. Whenever anything is pending inside the stop-grant window, a wake request output goes high. That output tells system logic to bring the whole package back to the normal state. The state of the interrupt-enable flag has no bearing on the wake request.

Once the stop-grant flag drops, the block hands the pending interrupts to the core one at a time over a valid/ready handshake. Each offer carries a two-bit type code and follows a fixed priority. The two local lines are maskable and wait while the interrupt-enable flag is clear. System-management and init go through regardless. The monitor event only wakes the package. Its pending bit is dropped on the way back to normal and it is never offered to the core.

Top module: `irq_wake_latch`

## Requirements
- R1: While reset is asserted and after it is released, no event is pending: `wake_req_o` and `dlv_valid_o` are both low, and a later exit from stop-grant offers nothing.
- R2: A source pulse sampled at a rising clock edge while `stop_grant_i` is high sets that source's pending bit. A pulse sampled while `stop_grant_i` is low is ignored: it never causes a delivery and does not raise `wake_req_o` on a later entry.
- R3: While `stop_grant_i` is high, `wake_req_o` is high from the cycle after the edge that latched the first interrupt or monitor event, and it stays high until stop-grant is left.
- R4: `wake_req_o` rises for pending maskable interrupts even when `irq_enable_i` is low.
- R5: `wake_req_o` is low in every cycle in which `stop_grant_i` is low.
- R6: No delivery is offered while `stop_grant_i` is high. Outside stop-grant, the offered type is the lowest eligible code, in the fixed order 2'b00 system-management, 2'b01 init, 2'b10 local line 0, 2'b11 local line 1.
- R7: A pending bit clears at the edge where `dlv_valid_o` and `dlv_ready_i` are both high and it is the offered type. However many pulses arrived on a source, that source is delivered exactly once.
- R8: The local lines (codes 2'b10 and 2'b11) are eligible only while `irq_enable_i` is high. While it is low they stay pending, and system-management and init are still delivered.
- R9: The monitor pending bit clears at the first edge with `stop_grant_i` low. It is never delivered, and re-entering stop-grant without a new event leaves `wake_req_o` low.
- R10: While `dlv_valid_o` is high and `dlv_ready_i` is low, with `stop_grant_i` and `irq_enable_i` unchanged, the offer and its type stay the same on the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_grant_i | input | 1 | High while the package is in the stop-grant state |
| irq_enable_i | input | 1 | Interrupt-enable flag of the core; gates the local lines only |
| smi_pulse_i | input | 1 | System-management interrupt pulse |
| init_pulse_i | input | 1 | Init interrupt pulse |
| lint_pulse_i | input | NUM_LINT | Local interrupt line pulses, bit 0 is line 0 |
| monitor_evt_i | input | 1 | Monitor event pulse |
| wake_req_o | output | 1 | Break-event request to system logic |
| dlv_valid_o | output | 1 | An interrupt is offered to the core |
| dlv_type_o | output | CODE_W | Type code of the offered interrupt |
| dlv_ready_i | input | 1 | Core accepts the offered interrupt |

## Verification
Leaving stop-grant does two things. The monitor pending bit is dropped, and the first interrupt is offered at once. A core that is already ready can accept that interrupt at the very same edge. The bench latches a system-management pulse together with a monitor event, then drops `stop_grant_i` while `dlv_ready_i` is already high, so the acceptance and the monitor clear share one edge. It then re-enters stop-grant on the next cycle and checks that `wake_req_o` stays low and no offer remains, which shows that both pending bits were consumed by that single edge.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

  // Type codes handed to the core; the numeric value is also the priority rank.
  typedef enum logic [1:0] {
    IRQ_SMI   = 2'b00,
    IRQ_INIT  = 2'b01,
    IRQ_LINT0 = 2'b10,
    IRQ_LINT1 = 2'b11
  } irq_code_e;

  // Number of sources that ignore the interrupt-enable flag (placed first).
  localparam int unsigned NUM_FIXED = 2;

  // Index of the lowest set bit of an eight-bit vector, zero when empty.
  function automatic logic [2:0] lowest_set(input logic [7:0] v);
    logic [2:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) r = i[2:0];
    end
    return r;
  endfunction

  // Mask with the maskable sources set: every source at or above NUM_FIXED.
  function automatic logic [7:0] maskable_bits(input int unsigned n_src);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i >= NUM_FIXED && i < n_src) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irqw_src_latch.sv
module irqw_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic pulse,
  input  logic consume,
  output logic pending
);

  // One sticky bit per source: repeated pulses collapse into one event.
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= 1'b0;
    else if (consume)              pend_q <= 1'b0;
    else if (capture_en && pulse)  pend_q <= 1'b1;
  end

  assign pending = pend_q;

  // R2: a captured pulse is visible on the next cycle
  a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && pulse && !consume) |=> pending);

  // R7: a consumed bit is gone on the next cycle
  a_r7_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !capture_en) |=> !pending);

endmodule

// File: rtl/irqw_prio_sel.sv
module irqw_prio_sel #(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] eligible,
  output logic               offer,
  output logic [CODE_W-1:0]  code,
  output logic [NUM_SRC-1:0] grant
);

  import irqw_pkg::*;

  // Prefix chain: a source wins when nothing of lower code is eligible.
  logic [NUM_SRC:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign grant[g]  = eligible[g] && !seen[g];
    assign seen[g+1] = seen[g] || eligible[g];
  end

  logic [7:0] elig_wide;
  assign elig_wide = 8'(eligible);
  assign offer     = seen[NUM_SRC];
  assign code      = CODE_W'(lowest_set(elig_wide));

  // R6: at most one source granted
  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: the chain and the encoder agree on the winner
  a_r6_code_matches: assert property (@(posedge clk) disable iff (!rst_n)
    offer |-> grant[code]);

endmodule

// File: rtl/irqw_wake_ctl.sv
module irqw_wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_grant,
  input  logic monitor_evt,
  input  logic irq_any,
  output logic exit_evt,
  output logic mon_pending,
  output logic wake_req
);

  logic sg_q;
  logic mon_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sg_q <= 1'b0;
    else        sg_q <= stop_grant;
  end

  // Exit from stop-grant: flag was high last cycle and is low now.
  assign exit_evt = sg_q && !stop_grant;

  // The monitor bit is cleared once stop-grant has been left for one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mon_q <= 1'b0;
    else if (!stop_grant)                mon_q <= 1'b0;
    else if (monitor_evt)                mon_q <= 1'b1;
  end

  assign mon_pending = mon_q;
  assign wake_req    = stop_grant && (irq_any || mon_q);

  // R9: monitor bit dropped after the exit edge
  a_r9_monitor_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (!mon_pending || stop_grant));

  // R3: a monitor event inside stop-grant raises the wake request next cycle
  a_r3_monitor_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_grant && monitor_evt) |=> (wake_req || !stop_grant));

  // R5: no wake request outside stop-grant
  a_r5_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_grant |-> !wake_req);

endmodule

// File: rtl/irq_wake_latch.sv
module irq_wake_latch #(
  parameter int unsigned NUM_LINT = 2,
  localparam int unsigned NUM_SRC = irqw_pkg::NUM_FIXED + NUM_LINT,
  localparam int unsigned CODE_W  = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_grant_i,
  input  logic                irq_enable_i,
  input  logic                smi_pulse_i,
  input  logic                init_pulse_i,
  input  logic [NUM_LINT-1:0] lint_pulse_i,
  input  logic                monitor_evt_i,
  output logic                wake_req_o,
  output logic                dlv_valid_o,
  output logic [CODE_W-1:0]   dlv_type_o,
  input  logic                dlv_ready_i
);

  import irqw_pkg::*;

  localparam logic [NUM_SRC-1:0] MASKABLE = NUM_SRC'(maskable_bits(NUM_SRC));

  logic [NUM_SRC-1:0] pulse_vec;
  logic [NUM_SRC-1:0] pend_w;
  logic [NUM_SRC-1:0] elig_w;
  logic [NUM_SRC-1:0] grant_w;
  logic [NUM_SRC-1:0] consume_w;
  logic               offer_w;
  logic               accept_w;
  logic               exit_w;
  logic               mon_pend_w;

  // Source order fixes the code: fixed sources first, then the local lines.
  assign pulse_vec = {lint_pulse_i, init_pulse_i, smi_pulse_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    irqw_src_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (stop_grant_i),
      .pulse      (pulse_vec[s]),
      .consume    (consume_w[s]),
      .pending    (pend_w[s])
    );
  end

  // Delivery only outside stop-grant; local lines also need the enable flag.
  assign elig_w = stop_grant_i ? '0
                : (pend_w & ~(MASKABLE & {NUM_SRC{!irq_enable_i}}));

  irqw_prio_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .eligible (elig_w),
    .offer    (offer_w),
    .code     (dlv_type_o),
    .grant    (grant_w)
  );

  assign dlv_valid_o = offer_w;
  assign accept_w    = offer_w && dlv_ready_i;
  assign consume_w   = accept_w ? grant_w : '0;

  irqw_wake_ctl u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_grant  (stop_grant_i),
    .monitor_evt (monitor_evt_i),
    .irq_any     (|pend_w),
    .exit_evt    (exit_w),
    .mon_pending (mon_pend_w),
    .wake_req    (wake_req_o)
  );

  // R6: nothing offered inside stop-grant
  a_r6_no_offer_in_sg: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant_i |-> !dlv_valid_o);

  // R2: no new pending bit appears outside stop-grant
  a_r2_no_capture_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_grant_i |=> ((pend_w & ~$past(pend_w)) == '0));

  // R7: the accepted source is cleared by the next cycle
  a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !stop_grant_i) |=> ((pend_w & $past(grant_w)) == '0));

  // R10: an offer not accepted keeps its source pending
  a_r10_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_o && !dlv_ready_i) |=> ((pend_w & $past(grant_w)) == $past(grant_w)));

  // R8: a masked local line is never offered
  a_r8_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_o && !irq_enable_i) |-> !MASKABLE[dlv_type_o]);

  // R9: monitor bit never outlives an exit edge
  a_r9_exit_drops_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_w && !stop_grant_i) |=> (!mon_pend_w || stop_grant_i));

endmodule

// File: tb/irq_wake_latch_tb.sv
module irq_wake_latch_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_grant_i = 1'b0;
  logic       irq_enable_i = 1'b1;
  logic       smi_pulse_i = 1'b0;
  logic       init_pulse_i = 1'b0;
  logic [1:0] lint_pulse_i = 2'b00;
  logic       monitor_evt_i = 1'b0;
  logic       wake_req_o;
  logic       dlv_valid_o;
  logic [1:0] dlv_type_o;
  logic       dlv_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_wake_latch u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_grant_i  (stop_grant_i),
    .irq_enable_i  (irq_enable_i),
    .smi_pulse_i   (smi_pulse_i),
    .init_pulse_i  (init_pulse_i),
    .lint_pulse_i  (lint_pulse_i),
    .monitor_evt_i (monitor_evt_i),
    .wake_req_o    (wake_req_o),
    .dlv_valid_o   (dlv_valid_o),
    .dlv_type_o    (dlv_type_o),
    .dlv_ready_i   (dlv_ready_i)
  );

  // Row: [13:10] sources pulsed (bit0 smi, bit1 init, bit2 lint0, bit3 lint1),
  // [9:6] sources pulsed a second time, [5] monitor, [4] enable flag,
  // [3] expected wake request, [2:0] expected deliveries with that flag.
  localparam int NROWS = 7;
  localparam logic [13:0] TAB [NROWS] = '{
    {4'b0001, 4'b0001, 1'b0, 1'b1, 1'b1, 3'd1},
    {4'b1111, 4'b0100, 1'b0, 1'b1, 1'b1, 3'd4},
    {4'b1100, 4'b0000, 1'b0, 1'b0, 1'b1, 3'd0},
    {4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 3'd0},
    {4'b0110, 4'b0010, 1'b1, 1'b0, 1'b1, 3'd1},
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 3'd0},
    {4'b1010, 4'b1000, 1'b0, 1'b1, 1'b1, 3'd2}
  };

  int got_n;
  logic [1:0] got_t [8];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_src(input logic [3:0] s, input logic mon);
    smi_pulse_i   = s[0];
    init_pulse_i  = s[1];
    lint_pulse_i  = s[3:2];
    monitor_evt_i = mon;
  endtask

  // Called just after a falling edge; stop-grant low, ready high, collects offers.
  task automatic drain(input logic ien);
    stop_grant_i = 1'b0;
    irq_enable_i = ien;
    dlv_ready_i  = 1'b1;
    got_n = 0;
    for (int k = 0; k < 6; k++) begin
      #1;
      if (dlv_valid_o) begin
        got_t[got_n] = dlv_type_o;
        got_n++;
      end
      @(negedge clk);
    end
    dlv_ready_i = 1'b0;
  endtask

  // Expected order restated from the requirements: ascending code, locals gated.
  task automatic expect_order(input logic [3:0] p, input logic ien,
                              output int n, output logic [1:0] t [8]);
    n = 0;
    for (int i = 0; i < 4; i++) begin
      if (p[i] && (i < 2 || ien)) begin
        t[n] = 2'(i);
        n++;
      end
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int         en;
    logic [1:0] et [8];
    logic [3:0] left;

    repeat (3) @(negedge clk);
    chk("R1 wake in reset", int'(wake_req_o), 0);
    chk("R1 valid in reset", int'(dlv_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    drain(1'b1);
    chk("R1 nothing pending after reset", got_n, 0);

    // Table walk
    for (int r = 0; r < NROWS; r++) begin
      logic [3:0] p;
      logic [3:0] d;
      p = TAB[r][13:10];
      d = TAB[r][9:6];
      stop_grant_i = 1'b1;
      irq_enable_i = TAB[r][4];
      @(negedge clk);
      drive_src(p, TAB[r][5]);
      @(negedge clk);
      drive_src(4'b0000, 1'b0);
      chk($sformatf("R3 R4 wake row %0d", r), int'(wake_req_o), int'(TAB[r][3]));
      chk($sformatf("R6 no offer in stop-grant row %0d", r), int'(dlv_valid_o), 0);
      @(negedge clk);
      drive_src(d, 1'b0);
      @(negedge clk);
      drive_src(4'b0000, 1'b0);
      chk($sformatf("R3 wake held row %0d", r), int'(wake_req_o), int'(TAB[r][3]));
      drain(TAB[r][4]);
      chk($sformatf("R5 wake low outside row %0d", r), int'(wake_req_o), 0);
      expect_order(p, TAB[r][4], en, et);
      chk($sformatf("R7 R8 count row %0d", r), got_n, int'(TAB[r][2:0]));
      chk($sformatf("R7 R8 model count row %0d", r), got_n, en);
      for (int k = 0; k < en && k < got_n; k++)
        chk($sformatf("R6 order row %0d slot %0d", r, k), int'(got_t[k]), int'(et[k]));
      // Masked local lines remain and come out once enabled.
      left = TAB[r][4] ? 4'b0000 : (p & 4'b1100);
      drain(1'b1);
      expect_order(left, 1'b1, en, et);
      chk($sformatf("R8 deferred count row %0d", r), got_n, en);
      for (int k = 0; k < en && k < got_n; k++)
        chk($sformatf("R8 deferred order row %0d", r), int'(got_t[k]), int'(et[k]));
      // Re-entry without events: nothing left, monitor included.
      stop_grant_i = 1'b1;
      @(negedge clk);
      chk($sformatf("R9 re-entry wake row %0d", r), int'(wake_req_o), 0);
      stop_grant_i = 1'b0;
      @(negedge clk);
    end

    // R2: pulses outside stop-grant are ignored
    drive_src(4'b1111, 1'b1);
    @(negedge clk);
    drive_src(4'b0000, 1'b0);
    #1;
    chk("R2 no offer from normal-state pulse", int'(dlv_valid_o), 0);
    @(negedge clk);
    stop_grant_i = 1'b1;
    @(negedge clk);
    chk("R2 no wake from normal-state pulse", int'(wake_req_o), 0);

    // R10: offer held while the core is not ready
    drive_src(4'b1001, 1'b0);
    @(negedge clk);
    drive_src(4'b0000, 1'b0);
    irq_enable_i = 1'b1;
    stop_grant_i = 1'b0;
    dlv_ready_i  = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 valid held", int'(dlv_valid_o), 1);
      chk("R10 type held", int'(dlv_type_o), 0);
      @(negedge clk);
    end
    dlv_ready_i = 1'b1;
    #1;
    chk("R7 smi offered", int'(dlv_type_o), 0);
    @(negedge clk);
    #1;
    chk("R7 next is lint1", int'(dlv_type_o), 3);
    @(negedge clk);
    #1;
    chk("R7 drained", int'(dlv_valid_o), 0);
    dlv_ready_i = 1'b0;
    @(negedge clk);

    // R9 with R7: exit edge accepts smi and drops monitor together
    stop_grant_i = 1'b1;
    @(negedge clk);
    drive_src(4'b0001, 1'b1);
    @(negedge clk);
    drive_src(4'b0000, 1'b0);
    stop_grant_i = 1'b0;
    dlv_ready_i  = 1'b1;
    #1;
    chk("R6 offer on exit cycle", int'(dlv_valid_o), 1);
    chk("R5 wake drops on exit", int'(wake_req_o), 0);
    @(negedge clk);
    stop_grant_i = 1'b1;
    dlv_ready_i  = 1'b0;
    #1;
    chk("R9 monitor cleared at exit edge", int'(wake_req_o), 0);
    chk("R7 smi consumed at exit edge", int'(dlv_valid_o), 0);
    @(negedge clk);

    // R1: reset discards pending events
    drive_src(4'b0011, 1'b1);
    @(negedge clk);
    drive_src(4'b0000, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 wake cleared by reset", int'(wake_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wake low after reset", int'(wake_req_o), 0);
    drain(1'b1);
    chk("R1 no delivery after reset", got_n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule